// File: doc/BRIEF.md
# Bit-Sliced Lockstep Stripe Distributor

This block spreads a wide stream of data words over a set of parallel drive lanes. It does not send whole blocks to one drive after another. Instead, every accepted word is cut into equal bit slices, and each lane receives its own fixed slice of every word. The combined width of the lane ports therefore equals the input width. The lanes move in lockstep. A word leaves the input only in a cycle where every lane can take its slice, so one slow drive holds back all of them.

The block also throttles the upstream data source by watching the occupancy of the stream buffer. It turns the source enable off when occupancy climbs to a high mark. It turns the enable back on only after occupancy has drained to a lower mark, and this gap keeps the enable from toggling every cycle. Two saturating counters support throughput measurement. One counts accepted words. The other counts cycles in which a word was offered but at least one lane held it back. The buffer controller and the drive protocol engines lie outside the block. The per-lane ready inputs and the occupancy input stand in for them.

Top module: `bitslice_stripe_dist`

## Requirements
- R1: In every cycle, lane k's data output carries bits [k*LANE_W +: LANE_W] of the input word, with lane 0 taking the least significant slice.
- R2: The lane valid outputs are either all high or all low. They are all high exactly when the input valid is high and every lane ready is high.
- R3: The input ready output is high exactly when every lane ready input is high, whatever the input valid is doing.
- R4: The accepted-word counter rises by one after each clock edge at which a word was accepted (input valid and input ready both high). At its all-ones value it holds.
- R5: The stall counter rises by one after each clock edge at which the input valid was high and at least one lane ready was low. At its all-ones value it holds. Cycles with input valid low do not change it.
- R6: After a clock edge at which the buffer level is at or above HI_MARK, the source enable is low. After an edge at which the level is at or below LO_MARK, it is high. After an edge with the level strictly between the two marks, it keeps its previous value.
- R7: While reset (active low) is asserted, both counters read zero and the source enable reads high.
- R8: Throttling the source has no effect on acceptance. A word offered while the source enable is low, or in the same cycle the enable drops, is still accepted and counted when all lanes are ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | N_LANES*LANE_W | Input word |
| in_ready | output | 1 | All lanes can take a slice |
| lane_valid | output | N_LANES | Per-lane slice valid, all equal |
| lane_data | output | N_LANES*LANE_W | Packed lane slices, lane k at [k*LANE_W +: LANE_W] |
| lane_ready | input | N_LANES | Per-lane ready from the drive engines |
| buf_level | input | LVL_W | Stream buffer occupancy |
| src_enable | output | 1 | Upstream source run enable |
| acc_count | output | CNT_W | Saturating count of accepted words |
| stall_count | output | CNT_W | Saturating count of held-back cycles |

## Verification
The source throttle and the word acceptance can fall in the same cycle. The buffer level can cross the high mark while a word is offered with every lane ready. The bench provokes this directly with a level at exactly HI_MARK and at exactly LO_MARK, each with a word offered. It also reaches this case through random levels that straddle both marks while the ready pattern varies. It judges the result by checking that the enable changes one cycle later while the accepted counter still advances on that same edge, and that the lane outputs stay unaffected by the enable.

// File: rtl/stripe_pkg.sv
package stripe_pkg;
   localparam int unsigned MAX_LANES = 32;

   typedef enum logic {
      GATE_PAUSED = 1'b0,
      GATE_RUNNING = 1'b1
   } gate_state_e;
endpackage

// File: rtl/stripe_slicer.sv
module stripe_slicer #(
   parameter int unsigned N_LANES = 8,
   parameter int unsigned LANE_W  = 20
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [N_LANES*LANE_W-1:0]   in_data,
   input  logic [N_LANES-1:0]          lane_ready,
   output logic                        in_ready,
   output logic                        take,
   output logic                        held,
   output logic [N_LANES-1:0]          lane_valid,
   output logic [N_LANES*LANE_W-1:0]   lane_data
);
   logic all_ready;

   assign all_ready = &lane_ready;
   assign in_ready  = all_ready;
   assign take      = in_valid & all_ready;
   assign held      = in_valid & ~all_ready;

   for (genvar k = 0; k < N_LANES; k++) begin : g_lane
      assign lane_valid[k] = take;
      assign lane_data[k*LANE_W +: LANE_W] = in_data[k*LANE_W +: LANE_W];

      AST_LANE_NEEDS_OWN_READY: assert property (@(posedge clk) disable iff (!rst_n)
         lane_valid[k] |-> lane_ready[k]); // R2
   end

   AST_NO_PARTIAL_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_valid == '0) || (lane_valid == '1)); // R2

   AST_TAKE_HELD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && held)); // R5
endmodule

// File: rtl/stripe_sat_counter.sv
module stripe_sat_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] TOP = '1;
   logic [CNT_W-1:0] cnt_q;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                  cnt_q <= '0;
         else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt_q <= '0;
         else if (inc) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

   AST_COUNT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1) || (!SATURATE && cnt_q == '0)); // R4

   AST_COUNT_ONLY_ON_INC: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/stripe_flow_gate.sv
module stripe_flow_gate
   import stripe_pkg::*;
#(
   parameter int unsigned LVL_W   = 10,
   parameter int unsigned HI_MARK = 768,
   parameter int unsigned LO_MARK = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] buf_level,
   output logic             src_enable
);
   localparam logic [LVL_W-1:0] HI = LVL_W'(HI_MARK);
   localparam logic [LVL_W-1:0] LO = LVL_W'(LO_MARK);

   gate_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= GATE_RUNNING;
      end else if (buf_level >= HI) begin
         state_q <= GATE_PAUSED;
      end else if (buf_level <= LO) begin
         state_q <= GATE_RUNNING;
      end
   end

   assign src_enable = (state_q == GATE_RUNNING);

   AST_EN_FALL_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_enable) |-> ($past(buf_level) >= HI)); // R6

   AST_EN_RISE_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_enable) |-> ($past(buf_level) <= LO)); // R6

   AST_EN_OFF_ABOVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_level >= HI) |=> !src_enable); // R6
endmodule

// File: rtl/bitslice_stripe_dist.sv
module bitslice_stripe_dist
   import stripe_pkg::*;
#(
   parameter int unsigned N_LANES = 8,
   parameter int unsigned LANE_W  = 20,
   parameter int unsigned DATA_W  = 160,
   parameter int unsigned LVL_W   = 10,
   parameter int unsigned HI_MARK = 768,
   parameter int unsigned LO_MARK = 256,
   parameter int unsigned CNT_W   = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [N_LANES*LANE_W-1:0]   in_data,
   output logic                        in_ready,
   output logic [N_LANES-1:0]          lane_valid,
   output logic [N_LANES*LANE_W-1:0]   lane_data,
   input  logic [N_LANES-1:0]          lane_ready,
   input  logic [LVL_W-1:0]            buf_level,
   output logic                        src_enable,
   output logic [CNT_W-1:0]            acc_count,
   output logic [CNT_W-1:0]            stall_count
);
   localparam int unsigned LVL_MAX = (1 << LVL_W) - 1;

   if (DATA_W != N_LANES * LANE_W) begin : g_bad_width
      $error("word width must equal lane count times lane width");
   end
   if (N_LANES < 1 || N_LANES > MAX_LANES) begin : g_bad_lanes
      $error("lane count out of supported range");
   end
   if (LO_MARK >= HI_MARK || HI_MARK > LVL_MAX) begin : g_bad_marks
      $error("watermarks must satisfy low < high <= level range");
   end

   logic take;
   logic held;

   stripe_slicer #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_slicer (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .lane_ready (lane_ready),
      .in_ready   (in_ready),
      .take       (take),
      .held       (held),
      .lane_valid (lane_valid),
      .lane_data  (lane_data)
   );

   stripe_flow_gate #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .buf_level  (buf_level),
      .src_enable (src_enable)
   );

   stripe_sat_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_acc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (take),
      .count (acc_count)
   );

   stripe_sat_counter #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_stall_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (held),
      .count (stall_count)
   );

   AST_ACCEPT_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (acc_count == $past(acc_count) + 1'b1) || (acc_count == '1)); // R4

   AST_ACCEPT_IGNORES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && &lane_ready) |-> (lane_valid == '1)); // R8

   AST_STALL_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> (stall_count == $past(stall_count) + 1'b1) || (stall_count == '1)); // R5
endmodule

// File: tb/test_bitslice_stripe_dist.sv
module test_bitslice_stripe_dist;
   localparam int N   = 8;
   localparam int LW  = 20;
   localparam int DW  = N * LW;
   localparam int VW  = 10;
   localparam int HI  = 768;
   localparam int LO  = 256;
   localparam int CW  = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          in_valid;
   logic [DW-1:0] in_data;
   logic          in_ready;
   logic [N-1:0]  lane_valid;
   logic [DW-1:0] lane_data;
   logic [N-1:0]  lane_ready;
   logic [VW-1:0] buf_level;
   logic          src_enable;
   logic [CW-1:0] acc_count;
   logic [CW-1:0] stall_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int exp_acc   = 0;
   int exp_stall = 0;
   bit exp_en    = 1'b1;

   always #5 clk = ~clk;

   bitslice_stripe_dist #(
      .N_LANES(N), .LANE_W(LW), .DATA_W(DW), .LVL_W(VW),
      .HI_MARK(HI), .LO_MARK(LO), .CNT_W(CW)
   ) i_bitslice_stripe_dist (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .lane_valid(lane_valid), .lane_data(lane_data),
      .lane_ready(lane_ready), .buf_level(buf_level), .src_enable(src_enable),
      .acc_count(acc_count), .stall_count(stall_count)
   );

   function automatic int sat_inc(int v, bit inc);
      if (inc && v < (1 << CW) - 1) return v + 1;
      return v;
   endfunction

   function automatic bit next_en(bit cur, int lvl);
      if (lvl >= HI) return 1'b0;
      if (lvl <= LO) return 1'b1;
      return cur;
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_comb();
      bit all_r;
      all_r = &lane_ready;
      chk(in_ready == all_r, "R3", in_ready, all_r);
      chk(lane_valid == {N{in_valid & all_r}}, "R2", lane_valid, {N{in_valid & all_r}});
      for (int k = 0; k < N; k++)
         chk(lane_data[k*LW +: LW] == in_data[k*LW +: LW], "R1",
             lane_data[k*LW +: LW], in_data[k*LW +: LW]);
   endtask

   task automatic check_regs();
      chk(acc_count == exp_acc, "R4", acc_count, exp_acc);
      chk(stall_count == exp_stall, "R5", stall_count, exp_stall);
      chk(src_enable == exp_en, "R6", src_enable, exp_en);
   endtask

   task automatic step(bit v, logic [DW-1:0] d, logic [N-1:0] r, int lvl);
      bit take;
      @(negedge clk);
      in_valid = v; in_data = d; lane_ready = r; buf_level = VW'(lvl);
      #1;
      check_comb();
      take = v & (&r);
      exp_acc   = sat_inc(exp_acc, take);
      exp_stall = sat_inc(exp_stall, v & ~(&r));
      exp_en    = next_en(exp_en, lvl);
      @(posedge clk);
      #1;
      check_regs();
   endtask

   function automatic logic [DW-1:0] rnd_word();
      logic [DW-1:0] w;
      for (int j = 0; j < DW; j += 32) w[j +: 32] = $urandom;
      return w;
   endfunction

   function automatic logic [N-1:0] rnd_ready();
      logic [N-1:0] r;
      for (int k = 0; k < N; k++) r[k] = ($urandom % 10) != 0;
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; lane_ready = '1; buf_level = '0;
      repeat (3) @(posedge clk);
      // R7: reset values, level held high while in reset
      @(negedge clk);
      buf_level = VW'(900); in_valid = 1'b1;
      @(posedge clk); #1;
      chk(acc_count == 0, "R7", acc_count, 0);
      chk(stall_count == 0, "R7", stall_count, 0);
      chk(src_enable == 1'b1, "R7", src_enable, 1);
      @(negedge clk);
      rst_n = 1'b1; in_valid = 1'b0;

      // R1: distinct marker per slice
      begin
         logic [DW-1:0] w;
         for (int k = 0; k < N; k++) w[k*LW +: LW] = LW'(k * 4097 + 3);
         step(1'b1, w, '1, 100);
      end
      // R5: one lane slow, word held back
      step(1'b1, rnd_word(), 8'b1111_0111, 100);
      // R5: idle cycles with a slow lane do not count stalls
      step(1'b0, rnd_word(), 8'b0000_0001, 100);
      // R3: ready without valid
      step(1'b0, rnd_word(), '1, 100);
      // R6/R8: level exactly at high mark while a word is accepted
      step(1'b1, rnd_word(), '1, HI);
      // R8: accepted while source throttled
      step(1'b1, rnd_word(), '1, 500);
      chk(src_enable == 1'b0, "R8", src_enable, 0);
      // R6: between marks holds low, then exactly low mark re-enables
      step(1'b1, rnd_word(), '1, LO + 1);
      step(1'b1, rnd_word(), '1, LO);
      step(1'b0, rnd_word(), '1, HI - 1);

      // random mix straddling both marks
      for (int i = 0; i < 2000; i++) begin
         int lvl;
         lvl = ($urandom % 4 == 0) ? ((($urandom % 2) == 0) ? HI : LO) : int'($urandom % 1024);
         step(($urandom % 4) != 0, rnd_word(), rnd_ready(), lvl);
      end

      // R4/R5: drive both counters to saturation
      for (int i = 0; i < 300; i++) step(1'b1, rnd_word(), '1, 0);
      chk(acc_count == 8'hFF, "R4", acc_count, 255);
      for (int i = 0; i < 300; i++) step(1'b1, rnd_word(), 8'b0111_1111, 0);
      chk(stall_count == 8'hFF, "R5", stall_count, 255);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule